// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Arbiter

This block arbitrates among a parameterised number of interrupting devices that share a single interrupt line and a single acknowledge line to a processor. Each device has its own stage in a serial chain. A stage keeps its device's request in a set/reset flag. The OR of all flags is presented to the processor as one interrupt output.

When the processor answers with an acknowledge, that signal enters the stage nearest the processor, which is stage 0. It then ripples down the chain. A stage with nothing pending passes the acknowledge on unchanged. A stage with a pending flag claims it, blocks it from every stage further down, and places its own fixed vector address on the shared vector output, together with a valid flag. Priority therefore follows physical position in the chain alone.

After service, software clears the device's flag through that device's clear input. Flag updates, whether set or clear, take effect only while the acknowledge is low. This keeps the winning vector steady for the whole time the acknowledge is held.

Top module: `daisy_chain_arbiter`

## Requirements
- R1: A synchronous active-low reset clears every flag. While reset is applied and on the cycle after it ends, int_o is 0, vec_valid_o is 0 and vec_o is 0, whatever req_i holds.
- R2: If req_i[i] is high at a rising edge while ack_i is low and clr_i[i] is low, flag i is set. The flag then stays set until it is cleared.
- R3: int_o is 1 exactly when at least one flag is set, and it is valid from the edge that changed the flags.
- R4: While ack_i is high and at least one flag is set, vec_valid_o is 1. In the same cycle, vec_o equals VEC_BASE + k*VEC_STRIDE (taken modulo 2^VEC_W), where k is the lowest index among the set flags. Index 0 is nearest the processor.
- R5: At most one stage claims the acknowledge at any time.
- R6: ack_pass_o, the acknowledge leaving the far end of the chain, equals ack_i when no flag is set and is 0 when any flag is set.
- R7: When ack_i is low, or when no flag is set, vec_valid_o is 0 and vec_o is 0.
- R8: req_i and clr_i are ignored at any edge where ack_i is high. The flags, int_o and vec_o keep their values.
- R9: If clr_i[i] is high at an edge where ack_i is low, flag i ends up clear even when req_i[i] is high at the same edge. Flags of other devices are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_DEV | Per-device request; sets that device's flag |
| clr_i | input | N_DEV | Per-device clear after service |
| ack_i | input | 1 | Interrupt acknowledge from the processor, entering stage 0 |
| int_o | output | 1 | Interrupt to the processor, high when any flag is set |
| ack_pass_o | output | 1 | Acknowledge leaving the last stage of the chain |
| vec_o | output | VEC_W | Vector address of the claiming stage, 0 when no stage claims |
| vec_valid_o | output | 1 | High when a stage has claimed the acknowledge |

## Verification
The bench builds the block with N_DEV = 4, VEC_W = 8, VEC_BASE = 0x40 and VEC_STRIDE = 3. With four devices, all 16 flag patterns can be reached and swept exhaustively. For each pattern, the bench first checks the interrupt line, the blocked acknowledge and the winning vector. It then drives inverted requests and clears while the acknowledge is held, to show that the flags stay frozen. Next it services the devices one by one in chain order, so every winner and every group of remaining flags is covered. Finally it drives a request and a clear on the same edge to show that the clear wins. The stride of 3 gives each stage a vector that is distinct from every other stage's and easy to compute.

// File: rtl/daisy_pkg.sv
`timescale 1ns/1ps
// daisy_pkg
// Shared helpers for the priority chain. Assumes vector addresses fit in
// 32 bits before they are truncated to the vector width.
package daisy_pkg;

    // Role a stage plays in the current cycle.
    typedef enum logic [1:0] {
        STG_IDLE  = 2'd0,   // no acknowledge arriving
        STG_PASS  = 2'd1,   // acknowledge forwarded downstream
        STG_CLAIM = 2'd2    // acknowledge captured, vector driven
    } stage_role_e;

    // Vector address assigned to stage idx.
    function automatic int unsigned stage_vector(input int unsigned base,
                                                 input int unsigned stride,
                                                 input int unsigned idx);
        return base + idx * stride;
    endfunction

endpackage

// File: rtl/daisy_flag.sv
`timescale 1ns/1ps
// daisy_flag
// Set/reset interrupt flag of one device. Clear wins over set. Both are
// sampled only while 'hold' (the acknowledge) is low, so the flag cannot
// move while the processor is reading a vector. Assumes synchronous
// active-low reset.
module daisy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Flag register: reset, frozen under hold, clear before set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!hold) begin
            if (clr) begin
                q <= 1'b0;
            end else if (set) begin
                q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/daisy_stage.sv
`timescale 1ns/1ps
// daisy_stage
// One link of the priority chain. It holds its device flag. A pending stage
// absorbs the incoming priority and drives its fixed vector. An idle stage
// forwards the priority unchanged. Assumes the chain is purely
// combinational from the acknowledge to the last link.
module daisy_stage
    import daisy_pkg::*;
#(
    parameter int unsigned     VEC_W = 8,
    parameter logic [VEC_W-1:0] VEC  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             req,
    input  logic             clr,
    input  logic             pri_in,
    output logic             pending,
    output logic             pri_out,
    output logic             claim,
    output logic [VEC_W-1:0] vec
);

    stage_role_e role;

    daisy_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .set   (req),
        .clr   (clr),
        .q     (pending)
    );

    // Decide what this link does with the incoming priority.
    always_comb begin
        if (!pri_in) begin
            role = STG_IDLE;
        end else if (pending) begin
            role = STG_CLAIM;
        end else begin
            role = STG_PASS;
        end
    end

    // Drive the chain output, the claim and the gated vector.
    always_comb begin
        pri_out = (role == STG_PASS);
        claim   = (role == STG_CLAIM);
        vec     = claim ? VEC : '0;
    end

endmodule

// File: rtl/daisy_vec_merge.sv
`timescale 1ns/1ps
// daisy_vec_merge
// Combines the gated vectors of all stages onto one bus. Assumes at most
// one stage drives a non-zero vector, so an OR is a correct merge.
module daisy_vec_merge #(
    parameter int unsigned N     = 4,
    parameter int unsigned VEC_W = 8
) (
    input  logic [N-1:0][VEC_W-1:0] vecs,
    input  logic [N-1:0]            claims,
    output logic [VEC_W-1:0]        vec,
    output logic                    valid
);

    // OR-reduce the per-stage vectors and claims.
    always_comb begin
        vec   = '0;
        valid = 1'b0;
        for (int i = 0; i < N; i++) begin
            vec   = vec | vecs[i];
            valid = valid | claims[i];
        end
    end

endmodule

// File: rtl/daisy_chain_arbiter.sv
`timescale 1ns/1ps
// daisy_chain_arbiter
// Top of the priority chain. Stage 0 is nearest the processor and takes
// ack_i directly. Each later stage takes the priority-out of the stage
// before it. Vectors are VEC_BASE + i*VEC_STRIDE, truncated to VEC_W.
// Assumes the caller chooses base and stride so the vectors are distinct.
module daisy_chain_arbiter #(
    parameter int unsigned N_DEV      = 8,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 32'h20,
    parameter int unsigned VEC_STRIDE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] req_i,
    input  logic [N_DEV-1:0] clr_i,
    input  logic             ack_i,
    output logic             int_o,
    output logic             ack_pass_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o
);

    localparam int unsigned LINKS = N_DEV + 1;

    logic [LINKS-1:0]            link;
    logic [N_DEV-1:0]            pending;
    logic [N_DEV-1:0]            claim;
    logic [N_DEV-1:0][VEC_W-1:0] stage_vec;

    // Feed the acknowledge into the head of the chain.
    assign link[0] = ack_i;

    for (genvar g = 0; g < N_DEV; g++) begin : g_stage
        daisy_stage #(
            .VEC_W (VEC_W),
            .VEC   (VEC_W'(daisy_pkg::stage_vector(VEC_BASE, VEC_STRIDE, g)))
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (ack_i),
            .req     (req_i[g]),
            .clr     (clr_i[g]),
            .pri_in  (link[g]),
            .pending (pending[g]),
            .pri_out (link[g+1]),
            .claim   (claim[g]),
            .vec     (stage_vec[g])
        );
    end

    daisy_vec_merge #(
        .N     (N_DEV),
        .VEC_W (VEC_W)
    ) u_merge (
        .vecs   (stage_vec),
        .claims (claim),
        .vec    (vec_o),
        .valid  (vec_valid_o)
    );

    // Shared interrupt line and far end of the chain.
    assign int_o      = |pending;
    assign ack_pass_o = link[N_DEV];

endmodule

// File: rtl/daisy_chain_arbiter_chk.sv
`timescale 1ns/1ps
// daisy_chain_arbiter_chk
// Property checker bound to the arbiter top. It observes the ports and
// the flag and claim vectors driven by the stages.
module daisy_chain_arbiter_chk #(
    parameter int unsigned N_DEV = 8,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEV-1:0] req_i,
    input logic [N_DEV-1:0] clr_i,
    input logic             ack_i,
    input logic             int_o,
    input logic             ack_pass_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_valid_o,
    input logic [N_DEV-1:0] pending,
    input logic [N_DEV-1:0] claim
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pending == '0));

    // R2
    req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((pending & ($past(req_i) & ~$past(clr_i)))
                    == ($past(req_i) & ~$past(clr_i))));

    // R4
    ack_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |-> vec_valid_o);

    // R5
    single_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim));

    // R6
    pass_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> !ack_pass_o);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i || !int_o) |-> (!vec_valid_o && vec_o == '0));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (pending == $past(pending)));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ((pending & $past(clr_i)) == '0));

endmodule

bind daisy_chain_arbiter daisy_chain_arbiter_chk #(
    .N_DEV (N_DEV),
    .VEC_W (VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .clr_i       (clr_i),
    .ack_i       (ack_i),
    .int_o       (int_o),
    .ack_pass_o  (ack_pass_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .pending     (pending),
    .claim       (claim)
);

// File: tb/tb_daisy_chain_arbiter.sv
`timescale 1ns/1ps
module tb_daisy_chain_arbiter;

    localparam int N = 4;
    localparam int W = 8;
    localparam int BASE = 32'h40;
    localparam int STRIDE = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] clr_i = '0;
    logic         ack_i = 1'b0;
    logic         int_o, ack_pass_o, vec_valid_o;
    logic [W-1:0] vec_o;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    daisy_chain_arbiter #(
        .N_DEV(N), .VEC_W(W), .VEC_BASE(BASE), .VEC_STRIDE(STRIDE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i),
        .ack_i(ack_i), .int_o(int_o), .ack_pass_o(ack_pass_o),
        .vec_o(vec_o), .vec_valid_o(vec_valid_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] p);
        for (int i = N - 1; i >= 0; i--) begin
            if (p[i]) lowest = i;
        end
        if (p == '0) lowest = -1;
    endfunction

    function automatic logic [W-1:0] vec_for(input int idx);
        return W'(BASE + idx * STRIDE);
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: requests during reset leave every flag clear
        req_i = '1;
        repeat (3) tick();
        #1;
        chk("R1 int", int_o, 0);
        chk("R1 valid", vec_valid_o, 0);
        req_i = '0;
        rst_n = 1'b1;
        tick();
        #1;
        chk("R1 int after", int_o, 0);
        chk("R1 vec after", vec_o, 0);

        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] pat;
            logic [N-1:0] rem;
            int win;
            pat = N'(p);
            // start from an empty chain
            clr_i = '1; tick(); clr_i = '0;
            // R2: one-cycle request pulse sets flags
            req_i = pat; tick(); req_i = '0;
            #1;
            chk("R3 int", int_o, pat != 0);
            chk("R7 valid no ack", vec_valid_o, 0);
            chk("R6 pass no ack", ack_pass_o, 0);
            // R4/R6: acknowledge picks the lowest pending index
            ack_i = 1'b1;
            #1;
            win = lowest(pat);
            chk("R4 valid", vec_valid_o, pat != 0);
            chk("R4 vec", vec_o, (pat != 0) ? vec_for(win) : 0);
            chk("R6 pass", ack_pass_o, pat == 0);
            // R8: inverted requests and clears under acknowledge are ignored
            req_i = ~pat; clr_i = pat; tick();
            req_i = '0; clr_i = '0;
            #1;
            chk("R8 vec frozen", vec_o, (pat != 0) ? vec_for(win) : 0);
            chk("R8 int frozen", int_o, pat != 0);
            ack_i = 1'b0;
            #1;
            chk("R7 vec idle", vec_o, 0);
            chk("R7 valid idle", vec_valid_o, 0);
            // R9: serve in chain order, clearing only the winner
            rem = pat;
            while (rem != '0) begin
                ack_i = 1'b1;
                #1;
                win = lowest(rem);
                chk("R4 serve vec", vec_o, vec_for(win));
                ack_i = 1'b0;
                clr_i = '0;
                clr_i[win] = 1'b1;
                tick();
                clr_i = '0;
                rem[win] = 1'b0;
                #1;
                chk("R9 others kept", int_o, rem != 0);
            end
            // R9: clear and request on the same edge leaves flags clear
            req_i = pat; clr_i = pat; tick();
            req_i = '0; clr_i = '0;
            #1;
            chk("R9 clear wins", int_o, 0);
            ack_i = 1'b1;
            #1;
            chk("R6 pass empty", ack_pass_o, 1);
            chk("R7 empty valid", vec_valid_o, 0);
            ack_i = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule